// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block receives stereo audio in slave mode. It samples a bit clock, a word-select line and a serial data line inside a faster system-clock domain. From these it builds one left and one right sample per frame and presents both as parallel 24-bit words. The block never drives the bit clock or the word-select line. It detects the bit-clock rising edges through a short synchronizer and takes the data and word-select levels on those edges.

A static 2-bit format input selects the alignment:

- **I2S mode.** The most significant bit follows the word-select edge by one bit clock. The word is filled from the top of the register, so a shorter word ends in zero low-order bits and bits past the twenty-fourth are dropped.
- **Right-aligned modes.** A continuously running shift register keeps the most recent bits. On the word-select edge, the last 16, 20 or 24 of them form the sample, and that sample is sign-extended to 24 bits.

A control machine has three states. `SEEK` waits after reset. `LEFT` collects the left channel (word select low). `RIGHT` collects the right channel. It moves between them on three named transitions:

- `seek_lock`: `SEEK` to `LEFT` on the first falling word-select edge.
- `left_done`: `LEFT` to `RIGHT` on a rising edge, which stores the left word.
- `frame_done`: `RIGHT` to `LEFT` on a falling edge, which publishes both words and pulses `valid`.

A half that runs past 32 bit clocks raises a one-cycle framing-error pulse.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is low and after it is released, `left`, `right`, `valid` and `frame_err` are all zero until the first completed frame or framing event.
- R2: After reset, no sample is published until a falling word-select edge has been seen and a full left half and right half have followed it. Any half in progress at reset is discarded.
- R3: With `fmt`=00 (I2S), the bit sampled one bit clock after a word-select edge becomes bit 23. Later bits fill the word downward, and word select low marks the left channel.
- R4: In I2S mode, a word shorter than 24 bits yields zeros in the unfilled low bits, and bits beyond the twenty-fourth in a half are ignored.
- R5: With `fmt`=01, 10 or 11, the sample is the last 16, 20 or 24 bits respectively before the word-select edge, with the LSB sampled on the last bit-clock rise before that edge. Bits sampled earlier in the half have no effect.
- R6: Right-aligned samples are sign-extended to 24 bits, copying bit 15 (for `fmt`=01) or bit 19 (for `fmt`=10) into all higher bits.
- R7: `valid` pulses for exactly one system clock once per frame, when the right half ends on a falling word-select edge. `left` and `right` then hold their values until the next such pulse.
- R8: `frame_err` pulses once when a 33rd bit-clock rise arrives within one word-select half. A half of exactly 32 bit clocks raises nothing.
- R9: `valid` and the new sample words appear on the third system-clock rising edge after the bit-clock rise that carries the closing word-select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck | input | 1 | Serial bit clock from the audio source |
| ws | input | 1 | Word select; low means left channel |
| sd | input | 1 | Serial data line |
| fmt | input | 2 | Static format: 00 I2S, 01 right-aligned 16, 10 right-aligned 20, 11 right-aligned 24 |
| left | output | 24 | Left sample, 24-bit two's complement |
| right | output | 24 | Right sample, 24-bit two's complement |
| valid | output | 1 | One-cycle strobe when a new stereo pair is published |
| frame_err | output | 1 | One-cycle pulse when a half exceeds 32 bit clocks |

## Verification
Each bit-clock rise passes through two synchronizer flops and one capture register. The outputs therefore change on the third system-clock edge after the rise that closes the frame. The bench records the cycle of that rise and the cycle where `valid` is seen, and checks that the gap is exactly three. The bit clock is held in each phase for four system clocks, and every frame task waits four more cycles after its final rise. As a result, sample comparisons run only after the strobe is due. A monitor counts strobes and error pulses on the falling system-clock edge, so a strobe that is missing or repeated shows up as a count mismatch.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int HALF_MAX = 32;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_RJ16 = 2'b01,
        FMT_RJ20 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_SEEK  = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } rx_state_e;

endpackage

// File: rtl/aud_rx_sync.sv
// Synchronizes the serial lines; bit 0 of din is the bit clock, whose rise is flagged.
module aud_rx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-2:0] dout,
    output logic         rise
);
    logic [W-1:0] pipe [STAGES];
    logic         clk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            clk_prev <= 1'b0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            clk_prev <= pipe[STAGES-1][0];
        end
    end

    assign rise = pipe[STAGES-1][0] & ~clk_prev;
    assign dout = pipe[STAGES-1][W-1:1];

    // A rise is a single-cycle event: needed for the fixed latency of R9.
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/aud_rx_core.sv
import aud_rx_pkg::*;

module aud_rx_core #(
    parameter int SW   = 24,
    parameter int HMAX = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ws,
    input  logic          sd,
    input  fmt_e          fmt,
    output logic [SW-1:0] raw_l,
    output logic [SW-1:0] raw_r,
    output logic          done,
    output logic          err
);
    localparam int CW = $clog2(HMAX + 2);
    localparam logic [CW-1:0] CNT_SAT = CW'(HMAX + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(HMAX);

    rx_state_e     state, state_nx;
    logic          ws_q;
    logic [CW-1:0] cnt;
    logic [SW-1:0] acc, acc_ins, shreg, hold_l, word_fin;
    logic          ws_edge;

    assign ws_edge = tick && (ws != ws_q);

    // I2S placement: the bit in slot cnt of a half lands at position SW-cnt
    always_comb begin
        acc_ins = acc;
        for (int b = 0; b < SW; b++) begin
            if (cnt == CW'(SW - b)) acc_ins[b] = sd;
        end
    end

    assign word_fin = (fmt == FMT_I2S) ? acc_ins : shreg;

    always_comb begin
        state_nx = state;
        if (ws_edge) begin
            unique case (state)
                ST_SEEK:  if (!ws) state_nx = ST_LEFT;   // seek_lock
                ST_LEFT:  if (ws)  state_nx = ST_RIGHT;  // left_done
                ST_RIGHT: if (!ws) state_nx = ST_LEFT;   // frame_done
                default:           state_nx = ST_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEEK;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q   <= 1'b0;
            cnt    <= '0;
            acc    <= '0;
            shreg  <= '0;
            hold_l <= '0;
            raw_l  <= '0;
            raw_r  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (tick) begin
                ws_q  <= ws;
                shreg <= {shreg[SW-2:0], sd};
                if (ws_edge) begin
                    cnt <= CW'(1);
                    acc <= '0;
                    if (state == ST_LEFT && ws) hold_l <= word_fin;
                    if (state == ST_RIGHT && !ws) begin
                        raw_l <= hold_l;
                        raw_r <= word_fin;
                        done  <= 1'b1;
                    end
                end else begin
                    acc <= acc_ins;
                    if (cnt != CNT_SAT) cnt <= cnt + CW'(1);
                    if (cnt == CNT_TOP) err <= 1'b1;
                end
            end
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_in_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == ST_LEFT);
    assert_no_publish_seek_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK) |-> !done);
    assert_err_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> cnt == CNT_SAT);
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

endmodule

// File: rtl/aud_rx_pack.sv
import aud_rx_pkg::*;

module aud_rx_pack #(
    parameter int SW = 24
) (
    input  fmt_e          fmt,
    input  logic [SW-1:0] raw,
    output logic [SW-1:0] word
);
    localparam int N_SHORT = SW - 8;
    localparam int N_MID   = SW - 4;

    always_comb begin
        unique case (fmt)
            FMT_I2S:  word = raw;
            FMT_RJ16: word = {{(SW-N_SHORT){raw[N_SHORT-1]}}, raw[N_SHORT-1:0]};
            FMT_RJ20: word = {{(SW-N_MID){raw[N_MID-1]}}, raw[N_MID-1:0]};
            default:  word = raw;
        endcase
    end

    always_comb begin
        if (fmt == FMT_RJ16)
            assert_sext16_R6: assert (word[SW-1:N_SHORT-1] == '0 || word[SW-1:N_SHORT-1] == '1);
        if (fmt == FMT_RJ20)
            assert_sext20_R6: assert (word[SW-1:N_MID-1] == '0 || word[SW-1:N_MID-1] == '1);
    end

endmodule

// File: rtl/aud_serial_rx.sv
import aud_rx_pkg::*;

module aud_serial_rx #(
    parameter int SW    = SAMPLE_W,
    parameter int HMAX  = HALF_MAX,
    parameter int SYNC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bck,
    input  logic          ws,
    input  logic          sd,
    input  logic [1:0]    fmt,
    output logic [SW-1:0] left,
    output logic [SW-1:0] right,
    output logic          valid,
    output logic          frame_err
);
    localparam int NCH = 2;

    logic [1:0]    sync_dat;
    logic          tick;
    logic [SW-1:0] raw_w  [NCH];
    logic [SW-1:0] word_w [NCH];
    fmt_e          fmt_t;

    assign fmt_t = fmt_e'(fmt);

    aud_rx_sync #(.STAGES(SYNC), .W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sd, ws, bck}),
        .dout (sync_dat),
        .rise (tick)
    );

    aud_rx_core #(.SW(SW), .HMAX(HMAX)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .ws   (sync_dat[0]),
        .sd   (sync_dat[1]),
        .fmt  (fmt_t),
        .raw_l(raw_w[0]),
        .raw_r(raw_w[1]),
        .done (valid),
        .err  (frame_err)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        aud_rx_pack #(.SW(SW)) u_pack (
            .fmt (fmt_t),
            .raw (raw_w[ch]),
            .word(word_w[ch])
        );
    end

    assign left  = word_w[0];
    assign right = word_w[1];

endmodule

// File: tb/aud_serial_rx_test.sv
`timescale 1ns/1ps
module aud_serial_rx_test;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [7:0]  h;
        logic [7:0]  w;
        logic [31:0] l;
        logic [31:0] r;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'd32, 8'd24, 32'h00123456, 32'h00ABCDEF, 24'h123456, 24'hABCDEF},
        '{2'b00, 8'd32, 8'd16, 32'h00008001, 32'h00007FFE, 24'h800100, 24'h7FFE00},
        '{2'b00, 8'd32, 8'd32, 32'hA5C3E1FF, 32'h12345678, 24'hA5C3E1, 24'h123456},
        '{2'b00, 8'd24, 8'd24, 32'h00800000, 32'h00000001, 24'h800000, 24'h000001},
        '{2'b01, 8'd32, 8'd16, 32'h00008001, 32'h00001234, 24'hFF8001, 24'h001234},
        '{2'b10, 8'd32, 8'd20, 32'h00080000, 32'h0007FFFF, 24'hF80000, 24'h07FFFF},
        '{2'b11, 8'd32, 8'd24, 32'h00C00003, 32'h003FFFFC, 24'hC00003, 24'h3FFFFC},
        '{2'b00, 8'd16, 8'd16, 32'h00004321, 32'h0000FFFF, 24'h432100, 24'hFFFF00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [23:0] left, right;
    logic        valid, frame_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int vcnt = 0;
    int ecnt = 0;
    int vcyc = 0;
    int rise_cyc = 0;
    logic [23:0] lat_l = '0, lat_r = '0;
    logic tail = 1'b0;
    logic primed = 1'b0;

    aud_serial_rx uut (
        .clk(clk), .rst_n(rst_n), .bck(bck), .ws(ws), .sd(sd), .fmt(fmt),
        .left(left), .right(right), .valid(valid), .frame_err(frame_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid) begin
            vcnt <= vcnt + 1;
            lat_l <= left;
            lat_r <= right;
            vcyc <= cyc;
        end
        if (frame_err) ecnt <= ecnt + 1;
    end

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_slot(input logic w, input logic d);
        bck = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        rise_cyc = cyc;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic slot_bit(input logic [1:0] f, input int h, input int w,
                                      input logic [31:0] word, input int i);
        int k;
        if (f == 2'b00) begin
            if (i == 0) return tail;
            return (i - 1 < w) ? word[w - i] : 1'b0;
        end
        k = i - (h - w);
        return (k >= 0) ? word[w - 1 - k] : 1'b1;
    endfunction

    task automatic send_half(input logic w, input logic [1:0] f, input int h, input int wl,
                             input logic [31:0] word, input int start);
        for (int i = start; i < h; i++) send_slot(w, slot_bit(f, h, wl, word, i));
        tail = (f == 2'b00 && wl == h) ? word[0] : 1'b0;
    endtask

    task automatic run_frame(input logic [1:0] f, input int hl, input int hr, input int wl,
                             input logic [31:0] l, input logic [31:0] r);
        fmt = f;
        send_half(1'b0, f, hl, wl, l, primed ? 1 : 0);
        send_half(1'b1, f, hr, wl, r, 0);
        send_slot(1'b0, slot_bit(f, hl, wl, 32'h0, 0));
        primed = 1'b1;
        @(negedge clk);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 3:    return "R3";
            1, 2, 7: return "R4";
            4:       return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(32'(left), 0, "R1 left in reset");
        check(32'(right), 0, "R1 right in reset");
        check(32'(valid), 0, "R1 valid in reset");
        check(32'(frame_err), 0, "R1 frame_err in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: partial right half before the first falling edge is discarded
        for (int i = 0; i < 5; i++) send_slot(1'b1, 1'b1);
        send_slot(1'b0, 1'b0);
        @(negedge clk);
        check(32'(vcnt), 0, "R2 no strobe before lock");
        primed = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            v0 = vcnt;
            run_frame(VECS[i].fmt, int'(VECS[i].h), int'(VECS[i].h), int'(VECS[i].w),
                      VECS[i].l, VECS[i].r);
            check(32'(vcnt - v0), 1, "R7 one strobe per frame");
            check(32'(lat_l), 32'(VECS[i].el), tag_of(i));
            check(32'(lat_r), 32'(VECS[i].er), tag_of(i));
        end
        // R9: latency from closing bit-clock rise to strobe
        check(32'(vcyc - rise_cyc), 3, "R9 strobe latency");
        // R7: outputs hold after the strobe
        check(32'(left), 32'(VECS[NV-1].el), "R7 left holds");
        check(32'(right), 32'(VECS[NV-1].er), "R7 right holds");
        // R8: 32-bit-clock halves raise nothing
        check(32'(ecnt), 0, "R8 no error at 32");

        // R8: a 33-slot left half
        run_frame(2'b00, 33, 32, 24, 32'h00654321, 32'h00111111);
        check(32'(ecnt), 1, "R8 error at 33");
        check(32'(lat_r), 32'h111111, "R8 right after long half");

        // R1 and R2: reset mid-run, then relock
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(32'(left), 0, "R1 left after reset");
        check(32'(valid), 0, "R1 valid after reset");
        rst_n = 1'b1;
        ws = 1'b1;
        @(negedge clk);
        primed = 1'b0;
        tail = 1'b0;
        for (int i = 0; i < 7; i++) send_slot(1'b1, 1'b0);
        v0 = vcnt;
        run_frame(2'b11, 32, 32, 24, 32'h00ABCDEF, 32'h00FEDCBA);
        check(32'(vcnt - v0), 1, "R2 single strobe after relock");
        check(32'(lat_l), 32'hABCDEF, "R2 left after relock");
        check(32'(lat_r), 32'hFEDCBA, "R5 right after relock");

        report();
        $finish;
    end

endmodule